// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs single read or write accesses to one external asynchronous memory region. A host raises a request with a direction flag, an address and write data. The block then drives chip-enable, output-enable and write-enable toward the memory, each with its own delay from the start of the access and its own pulse length. It drives the address and write data, captures read data, waits out a programmable idle gap, and signals completion with a one-clock done pulse.

The timing values come from configuration inputs that a register bank holds. Delays are stored directly. Pulse lengths and the access length are stored minus one. The external bus is either as wide as the host word or half as wide. On the half-width bus, every host access becomes two byte accesses. The chip-enable pin can be set active-low or active-high. The pulse and cycle fields are parameterised: a 4-bit field allows up to 16 clocks, and widening it to 5 bits gives the 32-clock variant.

Top module: `amem_strobe_seq`

## Requirements
- R1: Access clocks are numbered from 0. A strobe with delay field S and width field W (which stores length minus 1) is asserted on access clocks S through S+W inclusive, and is inactive on every other clock.
- R2: A read asserts chip-enable and output-enable and holds write-enable high. A write asserts chip-enable and write-enable and holds output-enable high. `mem_dq_oe` is 1 on every access clock of a write and 0 at all other times. Output-enable and write-enable are never low together.
- R3: An access lasts the largest of three lengths: cycle field + 1, chip-enable delay + width, and the delay + width of the strobe used in that direction. A short cycle field therefore stretches the access.
- R4: After each access, `cfg_idle_len` clocks (0 to 3) follow with all strobes inactive and the data bus not driven.
- R5: `done` is high for exactly one clock, on the clock after the last idle gap. All strobes are inactive during that clock and the clock after it.
- R6: With `cfg_bus_wide`=1, a host access is one external access at `req_addr`, carrying all 16 data bits.
- R7: With `cfg_bus_wide`=0, a host access is two external accesses. The first carries the low byte at `req_addr`. The second carries the high byte at `req_addr`+1, modulo 2^16. Write bytes go out on `mem_dq_out[7:0]` with the upper bits 0. Each byte access has its own idle gap. `done` follows only the second gap.
- R8: Read data is sampled from `mem_dq_in` at the clock edge that ends the last output-enable clock. On the narrow bus, the first byte fills `rd_data[7:0]` and the second fills `rd_data[15:8]`, both taken from `mem_dq_in[7:0]`. `rd_data` is valid from the done clock until the next read.
- R9: `mem_ce` equals `cfg_ce_high` while chip-enable is active and its inverse otherwise.
- R10: A request is taken only while the block is idle (never during an access, an idle gap or the done clock). Requests seen at other times are dropped.
- R11: During and right after reset, all strobes are inactive, `mem_dq_oe`=0, `done`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host address |
| req_wdata | input | 16 | Host write data |
| cfg_bus_wide | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_ce_high | input | 1 | 1 = chip-enable active-high |
| cfg_ce_setup | input | 4 | Chip-enable delay in clocks |
| cfg_oe_setup | input | 4 | Output-enable delay in clocks |
| cfg_we_setup | input | 4 | Write-enable delay in clocks |
| cfg_ce_width_m1 | input | 4 | Chip-enable length minus 1 |
| cfg_oe_width_m1 | input | 4 | Output-enable length minus 1 |
| cfg_we_width_m1 | input | 4 | Write-enable length minus 1 |
| cfg_cycle_m1 | input | 4 | Access length minus 1 |
| cfg_idle_len | input | 2 | Idle clocks after each access |
| mem_ce | output | 1 | Chip-enable pin, polarity per `cfg_ce_high` |
| mem_oe_n | output | 1 | Output-enable pin, active low |
| mem_we_n | output | 1 | Write-enable pin, active low |
| mem_addr | output | 16 | External address |
| mem_dq_out | output | 16 | Write data toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from memory |
| rd_data | output | 16 | Assembled read data |
| done | output | 1 | One-clock completion pulse |

## Verification
The checker watches on every clock that output-enable and write-enable are never low together, that the data bus is never driven while output-enable is low, and that `done` lasts one clock with all strobes inactive during it and after it. Strobe placement, stretching, gap length, byte splitting, address stepping, read assembly, polarity and the dropping of late requests all depend on configuration. The bench's per-clock reference model covers these over a set of configurations, including zero delays, single-clock pulses, the longest delay, a cycle field shorter than the pulses, and both bus widths.

// File: rtl/amem_pkg.sv
// Shared types for the asynchronous memory strobe sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package amem_pkg;

    // Sequencer phases: waiting, strobing, idle gap, completion pulse.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACC  = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_t;

    // Index of each strobe in the window array.
    localparam int unsigned STB_CE    = 0;
    localparam int unsigned STB_OE    = 1;
    localparam int unsigned STB_WE    = 2;
    localparam int unsigned STB_COUNT = 3;

endpackage

// File: rtl/amem_strobe_win.sv
// Window decoder for one strobe. It is active while the access clock
// counter lies between the delay and the delay plus the stored width.
// Assumes CNT_W can hold the largest delay plus width without overflow.
module amem_strobe_win #(
    parameter int SETUP_W = 4,
    parameter int PULSE_W = 4,
    parameter int CNT_W   = 5
) (
    input  logic               en,
    input  logic [CNT_W-1:0]   tick,
    input  logic [SETUP_W-1:0] setup,
    input  logic [PULSE_W-1:0] width_m1,
    output logic [CNT_W-1:0]   last_tick,
    output logic               on
);

    // Index of the final active clock of this strobe.
    assign last_tick = CNT_W'(setup) + CNT_W'(width_m1);

    // Active inside [setup, last_tick] while enabled.
    assign on = en && (tick >= CNT_W'(setup)) && (tick <= last_tick);

endmodule

// File: rtl/amem_span_calc.sv
// Computes the index of the last clock of an access. This is the largest
// of the cycle field, the chip-enable end and the end of the strobe used
// in the current direction. Purely combinational.
// Assumes CNT_W >= PULSE_W.
module amem_span_calc #(
    parameter int PULSE_W = 4,
    parameter int CNT_W   = 5
) (
    input  logic [PULSE_W-1:0] cycle_m1,
    input  logic [CNT_W-1:0]   ce_last,
    input  logic [CNT_W-1:0]   oe_last,
    input  logic [CNT_W-1:0]   we_last,
    input  logic               is_read,
    output logic [CNT_W-1:0]   acc_last
);

    logic [CNT_W-1:0] dir_last;

    // Pick the largest end index so the access covers every pulse.
    always_comb begin
        dir_last = is_read ? oe_last : we_last;
        acc_last = CNT_W'(cycle_m1);
        if (ce_last > acc_last)  acc_last = ce_last;
        if (dir_last > acc_last) acc_last = dir_last;
    end

endmodule

// File: rtl/amem_seq_fsm.sv
// Access sequencer. It takes a request when idle, counts access clocks
// up to acc_last, inserts the idle gap, repeats for the second byte on a
// narrow bus, then raises done for one clock.
// Assumes configuration stays stable from the request until done.
module amem_seq_fsm
    import amem_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int IDLE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic              wide,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic [CNT_W-1:0]  acc_last,
    output logic              accept,
    output logic              in_acc,
    output logic              is_read,
    output logic              phase,
    output logic [CNT_W-1:0]  tick,
    output logic              done
);

    seq_state_t        state;
    logic [IDLE_W-1:0] gap_cnt;
    logic              more;

    // A second byte access is pending on a narrow bus.
    assign more   = !phase && !wide;
    assign accept = (state == SEQ_IDLE) && req;
    assign in_acc = (state == SEQ_ACC);
    assign done   = (state == SEQ_DONE);

    // State, access clock counter, gap counter and byte phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            tick    <= '0;
            gap_cnt <= '0;
            phase   <= 1'b0;
            is_read <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (req) begin
                        is_read <= !req_write;
                        tick    <= '0;
                        phase   <= 1'b0;
                        state   <= SEQ_ACC;
                    end
                end
                SEQ_ACC: begin
                    if (tick == acc_last) begin
                        tick <= '0;
                        if (idle_len != '0) begin
                            gap_cnt <= IDLE_W'(1);
                            state   <= SEQ_GAP;
                        end else if (more) begin
                            phase <= 1'b1;
                            state <= SEQ_ACC;
                        end else begin
                            state <= SEQ_DONE;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                SEQ_GAP: begin
                    if (gap_cnt == idle_len) begin
                        if (more) begin
                            phase <= 1'b1;
                            state <= SEQ_ACC;
                        end else begin
                            state <= SEQ_DONE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/amem_byte_lane.sv
// Address and data path. It latches the host address and write data on
// accept, steps the address for the second byte, selects the byte lane
// for narrow writes and assembles read bytes.
// Assumes DATA_W is even; the narrow bus is DATA_W/2 bits wide.
module amem_byte_lane #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              phase,
    input  logic              wide,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] ext_din,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_dout_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int NARROW_W = DATA_W / 2;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Hold the host address and data for the whole host access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    assign ext_addr    = addr_q + ADDR_W'(phase);
    assign ext_dout_en = drive;

    // Put the byte for the current phase on the low lane of a narrow bus.
    always_comb begin
        if (wide) begin
            ext_dout = wdata_q;
        end else begin
            ext_dout = '0;
            ext_dout[NARROW_W-1:0] = phase ? wdata_q[DATA_W-1:NARROW_W]
                                           : wdata_q[NARROW_W-1:0];
        end
    end

    // Capture read data into the full word or into one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            if (wide)
                rdata <= ext_din;
            else if (phase)
                rdata[DATA_W-1:NARROW_W] <= ext_din[NARROW_W-1:0];
            else
                rdata[NARROW_W-1:0] <= ext_din[NARROW_W-1:0];
        end
    end

endmodule

// File: rtl/amem_strobe_seq.sv
// Top of the asynchronous memory strobe sequencer. It decodes the three
// strobes from one access clock counter and applies the chip-enable
// polarity. It assumes the cfg_* inputs come from a register bank and
// stay unchanged from a request until its done pulse.
module amem_strobe_seq
    import amem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int SETUP_W = 4,
    parameter int PULSE_W = 4,
    parameter int IDLE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               cfg_bus_wide,
    input  logic               cfg_ce_high,
    input  logic [SETUP_W-1:0] cfg_ce_setup,
    input  logic [SETUP_W-1:0] cfg_oe_setup,
    input  logic [SETUP_W-1:0] cfg_we_setup,
    input  logic [PULSE_W-1:0] cfg_ce_width_m1,
    input  logic [PULSE_W-1:0] cfg_oe_width_m1,
    input  logic [PULSE_W-1:0] cfg_we_width_m1,
    input  logic [PULSE_W-1:0] cfg_cycle_m1,
    input  logic [IDLE_W-1:0]  cfg_idle_len,
    output logic               mem_ce,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in,
    output logic [DATA_W-1:0]  rd_data,
    output logic               done
);

    localparam int CNT_W = ((SETUP_W > PULSE_W) ? SETUP_W : PULSE_W) + 1;

    logic                 accept, in_acc, is_read, phase, capture;
    logic [CNT_W-1:0]     tick, acc_last;
    logic [SETUP_W-1:0]   win_setup [STB_COUNT];
    logic [PULSE_W-1:0]   win_width [STB_COUNT];
    logic [CNT_W-1:0]     win_last  [STB_COUNT];
    logic [STB_COUNT-1:0] win_en, win_on;

    // Per-strobe configuration and direction gating.
    assign win_setup[STB_CE] = cfg_ce_setup;
    assign win_setup[STB_OE] = cfg_oe_setup;
    assign win_setup[STB_WE] = cfg_we_setup;
    assign win_width[STB_CE] = cfg_ce_width_m1;
    assign win_width[STB_OE] = cfg_oe_width_m1;
    assign win_width[STB_WE] = cfg_we_width_m1;
    assign win_en[STB_CE]    = in_acc;
    assign win_en[STB_OE]    = in_acc && is_read;
    assign win_en[STB_WE]    = in_acc && !is_read;

    // One window decoder per strobe.
    for (genvar g = 0; g < STB_COUNT; g++) begin : g_win
        amem_strobe_win #(
            .SETUP_W (SETUP_W),
            .PULSE_W (PULSE_W),
            .CNT_W   (CNT_W)
        ) u_win (
            .en        (win_en[g]),
            .tick      (tick),
            .setup     (win_setup[g]),
            .width_m1  (win_width[g]),
            .last_tick (win_last[g]),
            .on        (win_on[g])
        );
    end

    amem_span_calc #(
        .PULSE_W (PULSE_W),
        .CNT_W   (CNT_W)
    ) u_span (
        .cycle_m1 (cfg_cycle_m1),
        .ce_last  (win_last[STB_CE]),
        .oe_last  (win_last[STB_OE]),
        .we_last  (win_last[STB_WE]),
        .is_read  (is_read),
        .acc_last (acc_last)
    );

    amem_seq_fsm #(
        .CNT_W  (CNT_W),
        .IDLE_W (IDLE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .wide      (cfg_bus_wide),
        .idle_len  (cfg_idle_len),
        .acc_last  (acc_last),
        .accept    (accept),
        .in_acc    (in_acc),
        .is_read   (is_read),
        .phase     (phase),
        .tick      (tick),
        .done      (done)
    );

    // Sample read data on the final output-enable clock.
    assign capture = win_on[STB_OE] && (tick == win_last[STB_OE]);

    amem_byte_lane #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .host_addr   (req_addr),
        .host_wdata  (req_wdata),
        .phase       (phase),
        .wide        (cfg_bus_wide),
        .drive       (in_acc && !is_read),
        .capture     (capture),
        .ext_din     (mem_dq_in),
        .ext_addr    (mem_addr),
        .ext_dout    (mem_dq_out),
        .ext_dout_en (mem_dq_oe),
        .rdata       (rd_data)
    );

    // Pin levels: chip-enable follows the programmed polarity.
    assign mem_ce   = cfg_ce_high ? win_on[STB_CE] : !win_on[STB_CE];
    assign mem_oe_n = !win_on[STB_OE];
    assign mem_we_n = !win_on[STB_WE];

endmodule

// File: rtl/amem_strobe_seq_chk.sv
// Protocol checker for the strobe sequencer, bound to every instance.
// It looks only at the top-level pins.
module amem_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_ce,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe,
    input logic cfg_ce_high,
    input logic done
);

    // R2
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R2
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_oe_n && mem_we_n && (mem_ce != cfg_ce_high) && !mem_dq_oe));

    // R5
    after_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

bind amem_strobe_seq amem_strobe_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_ce      (mem_ce),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dq_oe   (mem_dq_oe),
    .cfg_ce_high (cfg_ce_high),
    .done        (done)
);

// File: tb/amem_strobe_seq_test.sv
`timescale 1ns/1ps
module amem_strobe_seq_test;

    typedef struct packed {
        logic        ce_act;
        logic        oe_act;
        logic        we_act;
        logic [15:0] addr;
        logic        dq_oe;
        logic [15:0] dq;
        logic        done;
        logic        chk_rd;
        logic [15:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        cfg_bus_wide = 1'b1, cfg_ce_high = 1'b0;
    logic [3:0]  cfg_ce_setup = '0, cfg_oe_setup = '0, cfg_we_setup = '0;
    logic [3:0]  cfg_ce_width_m1 = '0, cfg_oe_width_m1 = '0, cfg_we_width_m1 = '0;
    logic [3:0]  cfg_cycle_m1 = 4'd1;
    logic [1:0]  cfg_idle_len = '0;
    logic        mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, done;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in, rd_data;

    int    n_tests = 0, n_fail = 0;
    bit    chk_on = 0, finished = 0;
    string cur_tag = "reset";
    exp_t  q[$];

    always #2 clk = !clk;

    // Memory content as a function of the address.
    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h21};
    endfunction

    // The bus reads back only while output-enable is low.
    assign mem_dq_in = mem_oe_n ? 16'h0000 : pat(mem_addr);

    amem_strobe_seq uut (.*);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %0h expected %0h", rq, cur_tag, act, exp);
        end
    endtask

    // Fill the expected per-clock queue for one host access.
    task automatic plan(input logic rd, input logic [15:0] a, input logic [15:0] d);
        int ces, ce_n, oes, oe_n, wes, we_n, len, phases;
        exp_t e;
        logic [15:0] p0, p1;
        ces  = int'(cfg_ce_setup);
        ce_n = ces + int'(cfg_ce_width_m1) + 1;
        oes  = int'(cfg_oe_setup);
        oe_n = oes + int'(cfg_oe_width_m1) + 1;
        wes  = int'(cfg_we_setup);
        we_n = wes + int'(cfg_we_width_m1) + 1;
        len  = int'(cfg_cycle_m1) + 1;
        if (ce_n > len) len = ce_n;
        if (rd && oe_n > len) len = oe_n;
        if (!rd && we_n > len) len = we_n;
        phases = cfg_bus_wide ? 1 : 2;
        e = '0;
        q.push_back(e);
        for (int p = 0; p < phases; p++) begin
            for (int t = 0; t < len; t++) begin
                e = '0;
                e.ce_act = (t >= ces) && (t < ce_n);
                e.oe_act = rd && (t >= oes) && (t < oe_n);
                e.we_act = !rd && (t >= wes) && (t < we_n);
                e.addr   = a + 16'(p);
                e.dq_oe  = !rd;
                e.dq     = cfg_bus_wide ? d : ((p == 0) ? {8'h00, d[7:0]} : {8'h00, d[15:8]});
                q.push_back(e);
            end
            for (int g = 0; g < int'(cfg_idle_len); g++) begin
                e = '0;
                q.push_back(e);
            end
        end
        e = '0;
        e.done   = 1'b1;
        e.chk_rd = rd;
        p0 = pat(a);
        p1 = pat(a + 16'd1);
        e.rd = cfg_bus_wide ? p0 : {p1[7:0], p0[7:0]};
        q.push_back(e);
    endtask

    // Compare the pins with the model on every clock, away from the edge.
    always @(negedge clk) begin : cmp
        exp_t e;
        if (chk_on) begin
            e = '0;
            if (q.size() != 0) e = q.pop_front();
            chk("R1/R9 ce", mem_ce, cfg_ce_high ? e.ce_act : !e.ce_act);
            chk("R1/R2 oe_n", mem_oe_n, !e.oe_act);
            chk("R1/R2 we_n", mem_we_n, !e.we_act);
            chk("R2/R4 dq_oe", mem_dq_oe, e.dq_oe);
            chk("R3/R5 done", done, e.done);
            if (e.ce_act) chk("R6/R7 addr", mem_addr, e.addr);
            if (e.dq_oe) chk("R6/R7 dq_out", mem_dq_out, e.dq);
            if (e.chk_rd) chk("R8 rd_data", rd_data, e.rd);
        end
    end

    // One host access; optionally pulse a late request mid-access.
    task automatic run(input string tag, input logic rd, input logic [15:0] a,
                       input logic [15:0] d, input bit intrude);
        @(posedge clk); #1;
        cur_tag = tag;
        req = 1'b1; req_write = !rd; req_addr = a; req_wdata = d;
        plan(rd, a, d);
        @(posedge clk); #1;
        req = 1'b0; req_addr = 16'hDEAD; req_wdata = 16'hBEEF;
        if (intrude) begin
            repeat (2) @(posedge clk);
            #1 req = 1'b1; req_write = rd; req_addr = 16'h0F0F;
            @(posedge clk); #1 req = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic timing(input logic [3:0] ces, cew, oes, oew, wes, wew, cyc,
                          input logic [1:0] idle);
        cfg_ce_setup = ces; cfg_ce_width_m1 = cew;
        cfg_oe_setup = oes; cfg_oe_width_m1 = oew;
        cfg_we_setup = wes; cfg_we_width_m1 = wew;
        cfg_cycle_m1 = cyc; cfg_idle_len = idle;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs during reset
        chk("R11 ce", mem_ce, 1'b1);
        chk("R11 oe_n", mem_oe_n, 1'b1);
        chk("R11 we_n", mem_we_n, 1'b1);
        chk("R11 dq_oe", mem_dq_oe, 1'b0);
        chk("R11 done", done, 1'b0);
        chk("R11 rd_data", rd_data, 16'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 done after reset", done, 1'b0);
        chk("R11 we_n after reset", mem_we_n, 1'b1);
        chk_on = 1;

        // R6: wide bus, ordinary timing
        cfg_bus_wide = 1'b1;
        timing(4'd1, 4'd5, 4'd2, 4'd2, 4'd2, 4'd2, 4'd7, 2'd1);
        run("R6 wide write", 1'b0, 16'h1234, 16'hA55A, 0);
        run("R8 wide read", 1'b1, 16'h4321, 16'h0, 0);

        // R1: zero delays and single-clock pulses
        timing(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 2'd0);
        run("R1 min write", 1'b0, 16'h0001, 16'h00FF, 0);
        run("R1 min read", 1'b1, 16'h0002, 16'h0, 0);

        // R7: narrow bus with address wrap
        cfg_bus_wide = 1'b0;
        timing(4'd1, 4'd3, 4'd1, 4'd2, 4'd2, 4'd1, 4'd5, 2'd2);
        run("R7 narrow write", 1'b0, 16'hFFFF, 16'hC3E1, 0);
        run("R7 narrow read", 1'b1, 16'h12FF, 16'h0, 0);

        // R4: longest and zero idle gaps on the narrow bus
        timing(4'd0, 4'd2, 4'd1, 4'd1, 4'd1, 4'd1, 4'd3, 2'd3);
        run("R4 gap3 read", 1'b1, 16'h0040, 16'h0, 0);
        cfg_idle_len = 2'd0;
        run("R4 gap0 write", 1'b0, 16'h0080, 16'h7E81, 0);

        // R3: short cycle field stretched by long delay plus pulse
        cfg_bus_wide = 1'b1;
        timing(4'd3, 4'd4, 4'd9, 4'd6, 4'd15, 4'd15, 4'd1, 2'd1);
        run("R3 stretch write", 1'b0, 16'h0A0A, 16'h1357, 0);
        run("R3 stretch read", 1'b1, 16'h0B0B, 16'h0, 0);

        // R9: active-high chip-enable
        cfg_ce_high = 1'b1;
        timing(4'd2, 4'd4, 4'd3, 4'd2, 4'd3, 4'd2, 4'd9, 2'd1);
        run("R9 high ce write", 1'b0, 16'h5555, 16'h2468, 0);
        cfg_bus_wide = 1'b0;
        run("R9 high ce read", 1'b1, 16'hAAAA, 16'h0, 0);

        // R10: request raised during an access is dropped
        cfg_ce_high = 1'b0;
        cfg_bus_wide = 1'b1;
        timing(4'd1, 4'd8, 4'd2, 4'd6, 4'd2, 4'd6, 4'd12, 2'd2);
        run("R10 late req", 1'b1, 16'h3000, 16'h0, 1);
        run("R10 late req write", 1'b0, 16'h3001, 16'h9999, 1);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog [%s]: actual hung expected finished", cur_tag);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule